// File: doc/BRIEF.md
# Stream Pattern Terminator for a DMA Channel

This block sits beside one DMA channel and watches the bytes the channel moves. When a programmed pattern of one or two bytes shows up in that byte stream, the block raises a single-cycle terminate pulse. The channel uses that pulse to end its current block transfer or linked-list transfer. The block can also treat one programmed byte value as filler. Bytes with that value are passed over without affecting the search.

Software programs a 32-bit configuration word over a plain write/read register port. The word holds a 16-bit pattern and an 8-bit skip value. The register refuses writes while the channel is enabled. Two level inputs come from a neighbouring control register: one selects two-byte matching and the other turns byte skipping on.

The byte stream uses valid/ready. The block asserts ready exactly while the channel is enabled and never applies any other back-pressure. A byte counts as accepted only in a cycle where valid and ready are both high. While ready is low, the producer must keep its byte, and nothing is examined.

Top module: `dma_pattern_stop`

## Requirements
- R1: After reset, the configuration read-back is 0x00000000, the terminate pulse is low and no partial match is held.
- R2: A write with the channel disabled stores bits 15:0 as the pattern and bits 31:24 as the skip value. Pattern bits 7:0 are the first byte and bits 15:8 are the second. The read-back shows these fields in the same positions, and bits 23:16 always read as zero.
- R3: A write made while `chan_en` is 1 is dropped, and the read-back keeps its previous value.
- R4: With `two_byte` low, an accepted byte equal to pattern bits 7:0 makes `term_pulse` high for exactly the one cycle after the acceptance edge.
- R5: With `two_byte` high, an accepted byte equal to pattern bits 7:0, followed by an accepted, non-skipped byte equal to pattern bits 15:8, produces the pulse in the cycle after the second byte.
- R6: With `skip_en` high, an accepted byte equal to the skip value has no effect. It neither advances nor clears a partial match, and it never triggers a pulse, even if it also equals a pattern byte.
- R7: With `skip_en` low, a byte equal to the skip value is matched like any other byte.
- R8: In two-byte mode, a non-skipped byte that is not the second pattern byte ends the partial match. That same byte is tested at once as a first byte.
- R9: `s_ready` equals `chan_en`. While `chan_en` is 0, no byte is accepted, `term_pulse` stays low, and any partial match is discarded.
- R10: A cycle with `s_valid` low changes neither the pulse nor the partial-match state.
- R11: After a completed match, the partial-match state is empty, so a lone second byte does not trigger again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel running; locks the configuration register |
| two_byte | input | 1 | Level: 1 selects two-byte pattern |
| skip_en | input | 1 | Level: 1 lets bytes equal to the skip value be ignored |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write word |
| cfg_rd_data | output | 32 | Configuration read-back |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready (equals chan_en) |
| s_data | input | 8 | Stream byte |
| term_pulse | output | 1 | One-cycle request to end the transfer |

## Verification
The configuration read-back is combinational from the register, so a write is visible in the cycle after its edge. The terminate pulse registers once, so it is due in the cycle after the edge at which the completing byte was accepted. It is gated by the present value of `chan_en`. The bench drives every input at the falling edge and samples one nanosecond later. Its model carries the pulse forward by exactly one rising edge, so each comparison is made against the byte accepted in the previous cycle.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HALF = 1'b1
  } pmt_state_e;

  localparam int PMT_LANES = 2;
endpackage

// File: rtl/pmt_cfg.sv
module pmt_cfg #(
  parameter int REG_W = 32,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [DW-1:0]    pat_lo,
  output logic [DW-1:0]    pat_hi,
  output logic [DW-1:0]    skip_val,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAT_W   = 2 * DW;
  localparam int SKIP_LSB = REG_W - DW;

  logic wr_ok;
  assign wr_ok = wr_en && !chan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_lo   <= '0;
      pat_hi   <= '0;
      skip_val <= '0;
    end else if (wr_ok) begin
      pat_lo   <= wr_data[DW-1:0];
      pat_hi   <= wr_data[PAT_W-1:DW];
      skip_val <= wr_data[REG_W-1:SKIP_LSB];
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[DW-1:0]              = pat_lo;
    rd_data[PAT_W-1:DW]          = pat_hi;
    rd_data[REG_W-1:SKIP_LSB]    = skip_val;
  end

  // R3: a write while the channel runs leaves the register untouched
  p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chan_en) |=> $stable(rd_data));

  // R2: an accepted write shows up in the read-back pattern field
  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chan_en) |=> (rd_data[PAT_W-1:0] == $past(wr_data[PAT_W-1:0])));
endmodule

// File: rtl/pmt_byte_cls.sv
module pmt_byte_cls #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] pat_lo,
  input  logic [DW-1:0] pat_hi,
  input  logic [DW-1:0] skip_val,
  input  logic          skip_en,
  output logic          is_skip,
  output logic          eq_lo,
  output logic          eq_hi
);
  import pmt_pkg::*;

  logic [PMT_LANES-1:0][DW-1:0] lane_pat;
  logic [PMT_LANES-1:0]         lane_eq;

  assign lane_pat[0] = pat_lo;
  assign lane_pat[1] = pat_hi;

  for (genvar g = 0; g < PMT_LANES; g++) begin : g_lane
    assign lane_eq[g] = (data == lane_pat[g]);
  end

  assign eq_lo   = lane_eq[0];
  assign eq_hi   = lane_eq[1];
  assign is_skip = skip_en && (data == skip_val);
endmodule

// File: rtl/pmt_seq.sv
module pmt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic acc,
  input  logic two_byte,
  input  logic is_skip,
  input  logic eq_lo,
  input  logic eq_hi,
  output logic pulse_q,
  output logic partial
);
  import pmt_pkg::*;

  pmt_state_e state_q, state_d;
  logic       hit;
  logic       half;

  assign half    = (state_q == ST_HALF) && two_byte;
  assign partial = (state_q == ST_HALF);

  always_comb begin
    state_d = state_q;
    hit     = 1'b0;
    if (!chan_en) begin
      state_d = ST_HUNT;
    end else if (acc && !is_skip) begin
      if (half && eq_hi) begin
        hit     = 1'b1;
        state_d = ST_HUNT;
      end else if (eq_lo) begin
        if (two_byte) begin
          state_d = ST_HALF;
        end else begin
          hit     = 1'b1;
          state_d = ST_HUNT;
        end
      end else begin
        state_d = ST_HUNT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= hit;
    end
  end

  // R4: a pulse only follows an accepted byte
  p_pulse_needs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(acc));

  // R9: a disabled channel holds no partial match next cycle
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !partial);

  // R6: a skipped byte keeps the partial-match state
  p_skip_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_skip) |=> $stable(partial));

  // R11: a completed match leaves no partial state
  p_hit_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !partial);

  // R10: with no accepted byte and channel running, the state holds
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && chan_en) |=> ($stable(partial) && !pulse_q));
endmodule

// File: rtl/dma_pattern_stop.sv
module dma_pattern_stop #(
  parameter int REG_W = 32,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             two_byte,
  input  logic             skip_en,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  output logic             term_pulse
);
  logic [DW-1:0] pat_lo, pat_hi, skip_val;
  logic          is_skip, eq_lo, eq_hi;
  logic          acc, pulse_q, partial;

  assign s_ready = chan_en;
  assign acc     = s_valid && s_ready;

  pmt_cfg #(.REG_W(REG_W), .DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .pat_lo   (pat_lo),
    .pat_hi   (pat_hi),
    .skip_val (skip_val),
    .rd_data  (cfg_rd_data)
  );

  pmt_byte_cls #(.DW(DW)) u_cls (
    .data     (s_data),
    .pat_lo   (pat_lo),
    .pat_hi   (pat_hi),
    .skip_val (skip_val),
    .skip_en  (skip_en),
    .is_skip  (is_skip),
    .eq_lo    (eq_lo),
    .eq_hi    (eq_hi)
  );

  pmt_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en),
    .acc      (acc),
    .two_byte (two_byte),
    .is_skip  (is_skip),
    .eq_lo    (eq_lo),
    .eq_hi    (eq_hi),
    .pulse_q  (pulse_q),
    .partial  (partial)
  );

  assign term_pulse = pulse_q && chan_en;

  // R9: no terminate request while the channel is off
  p_no_pulse_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !term_pulse);
endmodule

// File: tb/dma_pattern_stop_tb.sv
`timescale 1ns/1ps
module dma_pattern_stop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, two_byte = 1'b0, skip_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        s_valid = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic        term_pulse;

  int n_cmp = 0, n_bad = 0;
  logic       m_half = 1'b0, m_pq = 1'b0;
  logic [7:0] m_lo = '0, m_hi = '0, m_skip = '0;

  always #2.5 clk = ~clk;

  dma_pattern_stop u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .two_byte(two_byte),
    .skip_en(skip_en), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .term_pulse(term_pulse)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // returns {hit, next_half}
  function automatic logic [1:0] model(input logic half, input logic en, input logic v,
                                       input logic [7:0] d, input logic l2, input logic sk);
    logic h;
    h = half && l2;
    if (!en) return 2'b00;
    if (!v || (sk && d == m_skip)) return {1'b0, half};
    if (h && d == m_hi) return 2'b10;
    if (d == m_lo) return l2 ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  task automatic step(input logic v, input logic [7:0] d, input logic en,
                      input logic l2, input logic sk, input string tag);
    logic [1:0] r;
    @(negedge clk);
    s_valid = v; s_data = d; chan_en = en; two_byte = l2; skip_en = sk;
    #1;
    chk({31'b0, term_pulse}, {31'b0, m_pq && en}, tag);
    chk({31'b0, s_ready}, {31'b0, en}, "R9");
    r = model(m_half, en, v, d, l2, sk);
    @(posedge clk);
    m_pq = r[1]; m_half = r[0];
  endtask

  task automatic reg_write(input logic [31:0] w, input logic en);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = w; chan_en = en; s_valid = 1'b0;
    @(posedge clk);
    if (!en) begin
      m_lo = w[7:0]; m_hi = w[15:8]; m_skip = w[31:24];
      m_half = 1'b0;
    end
    m_pq = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic l2, sk, en, v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(cfg_rd_data, 32'h0, "R1");
    chk({31'b0, term_pulse}, 32'h0, "R1");
    step(1'b1, 8'h00, 1'b1, 1'b1, 1'b0, "R1");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1");

    reg_write(32'hABFF_3412, 1'b0);
    #1 chk(cfg_rd_data, 32'hAB00_3412, "R2");
    reg_write(32'h0000_0000, 1'b1);
    #1 chk(cfg_rd_data, 32'hAB00_3412, "R3");
    reg_write(32'hAB00_3412, 1'b0);

    // R4 one-byte mode, pulse one cycle wide
    step(1'b1, 8'h12, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R4");
    // R5 two-byte
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R5");
    // R6 skipped byte between
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b1, 8'hAB, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R6");
    // R7 skip disabled
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 8'hAB, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R7");
    // R8 restart
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h55, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R8");
    // R9 disable drops partial, disabled bytes not accepted
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 8'h34, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 8'h12, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
    // R10 valid low holds partial
    step(1'b1, 8'h12, 1'b1, 1'b1, 1'b0, "R10");
    step(1'b0, 8'h34, 1'b1, 1'b1, 1'b0, "R10");
    step(1'b0, 8'h55, 1'b1, 1'b1, 1'b0, "R10");
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R10");
    // R11 lone second byte after hit
    step(1'b1, 8'h34, 1'b1, 1'b1, 1'b0, "R11");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R11");
    // R6 skip value equal to first pattern byte wins
    reg_write(32'h1200_3412, 1'b0);
    step(1'b1, 8'h12, 1'b1, 1'b0, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R6");
    step(1'b1, 8'h12, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R7");

    // random phase
    l2 = 1'b1; sk = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0)
        reg_write({4'h0, 4'($urandom_range(0, 3)), 16'h0,
                   4'h0, 4'($urandom_range(0, 3)), 4'h0, 4'($urandom_range(0, 3))}, 1'b0);
      if ($urandom_range(0, 19) == 0) l2 = ~l2;
      if ($urandom_range(0, 19) == 0) sk = ~sk;
      v  = ($urandom_range(0, 3) != 0);
      en = ($urandom_range(0, 19) != 0);
      case ($urandom_range(0, 3))
        0: d = m_lo;
        1: d = m_hi;
        2: d = m_skip;
        default: d = 8'($urandom_range(0, 3));
      endcase
      step(v, d, en, l2, sk, l2 ? "R5" : "R4");
    end
    step(1'b0, 8'h00, 1'b1, l2, sk, "R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule